// File: doc/BRIEF.md
# Sampled Pulse-Rate Counter

This block counts rising edges on an external horizontal-sync pulse train so that software can work out its line frequency. The raw pulse enters a two-flop synchroniser clocked by the system clock. An internal strobe, generated by dividing the system clock by three, then samples the synchronised level. Each low-to-high transition between two strobe samples adds one to an 8-bit count.

Software opens a measurement window by reading the counter, which also clears it. It waits a fixed time and reads again. The read request is carried out on the next sample strobe, so the count update and the read/clear happen in the same clock cycle. An edge that arrives in that same cycle is kept.

Top module: `pulse_rate_counter`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the count and `rd_data_o` are zero and the sample-strobe phase restarts.
- R2: The sample strobe fires in exactly one system clock cycle of every three, the first time in the third cycle after reset is released.
- R3: The input passes through two synchroniser flops. A rising edge is a strobe sample of 1 whose previous strobe sample was 0, and each such edge adds exactly one to the count.
- R4: The count wraps from 255 to 0 on the next edge; it never saturates.
- R5: A pulse that stays high for at least four system clocks and then low for at least four is always counted once.
- R6: A one-cycle `rd_i` pulse is served on the next strobe cycle, or in the same cycle if the strobe is active. Serving loads the count into `rd_data_o` and clears the count.
- R7: If a rising edge is detected in the same cycle that a read is served, the read returns the old count and the count restarts at 1.
- R8: `rd_data_o` changes only when a read is served. Further `rd_i` pulses that arrive while a read is still pending are merged into that one read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high power-on reset, synchronous |
| hs_raw_i | input | 1 | Asynchronous pulse input to be counted |
| rd_i | input | 1 | Single-cycle read-and-clear request |
| rd_data_o | output | 8 | Count captured by the last served read |

## Verification
The hardest case to reach from the ports is an edge detected in exactly the strobe cycle in which a pending read is served. Reaching it needs the synchroniser delay, the divide-by-three phase and the read timing to line up. The bench holds the input high and follows its own reference model of the strobe phase and of the synchronised samples. It raises `rd_i` at the one falling clock edge before which the model predicts a detected edge on a strobe cycle. It then checks that this read returns the old count and that the next read returns 1. Counts of 255 and 257 pulses cover the top of the range and the wrap.

// File: rtl/prc_pkg.sv
package prc_pkg;
   // Width of a phase counter that must hold values 0 .. div-1.
   function automatic int unsigned prc_phase_w(input int unsigned div);
      int unsigned w;
      w = $clog2(div);
      return (w < 1) ? 1 : w;
   endfunction
endpackage

// File: rtl/prc_strobe_gen.sv
module prc_strobe_gen
   import prc_pkg::*;
#(
   parameter int unsigned DIV = 3
) (
   input  logic clk,
   input  logic rst,
   output logic strobe_o
);
   localparam int unsigned PW = prc_phase_w(DIV);
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] ph_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q <= '0;
      end else if (ph_q == LAST) begin
         ph_q <= '0;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assign strobe_o = (ph_q == LAST);
endmodule

// File: rtl/prc_sync.sv
module prc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_i,
   output logic sync_o
);
   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain_q[0] <= 1'b0;
            else     chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/prc_edge_det.sv
module prc_edge_det (
   input  logic clk,
   input  logic rst,
   input  logic strobe_i,
   input  logic level_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst)           prev_q <= 1'b0;
      else if (strobe_i) prev_q <= level_i;
   end

   assign rise_o = strobe_i & level_i & ~prev_q;
endmodule

// File: rtl/prc_count_core.sv
module prc_count_core #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             strobe_i,
   input  logic             rise_i,
   input  logic             rd_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             pend_o,
   output logic [CNT_W-1:0] data_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, data_q;
   logic             pend_q, serve;

   assign serve = strobe_i & (pend_q | rd_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         data_q <= '0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= serve ? 1'b0 : (pend_q | rd_i);
         if (serve) begin
            data_q <= cnt_q;
            cnt_q  <= rise_i ? ONE : '0;
         end else if (rise_i) begin
            cnt_q  <= cnt_q + ONE;
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign pend_o = pend_q;
   assign data_o = data_q;
endmodule

// File: rtl/pulse_rate_counter.sv
module pulse_rate_counter #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SAMPLE_DIV  = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hs_raw_i,
   input  logic             rd_i,
   output logic [CNT_W-1:0] rd_data_o
);
   if (CNT_W < 2) begin : g_bad_width
      $error("pulse_rate_counter: CNT_W must be at least 2");
   end
   if (SAMPLE_DIV < 2) begin : g_bad_div
      $error("pulse_rate_counter: SAMPLE_DIV must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pulse_rate_counter: SYNC_STAGES must be at least 2");
   end

   logic             smp_stb;
   logic             hs_sync;
   logic             edge_rise;
   logic             rd_pend;
   logic [CNT_W-1:0] cnt_q;

   prc_strobe_gen #(.DIV(SAMPLE_DIV)) u_stb (
      .clk(clk), .rst(rst), .strobe_o(smp_stb)
   );

   prc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_i(hs_raw_i), .sync_o(hs_sync)
   );

   prc_edge_det u_edge (
      .clk(clk), .rst(rst), .strobe_i(smp_stb), .level_i(hs_sync),
      .rise_o(edge_rise)
   );

   prc_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst(rst), .strobe_i(smp_stb), .rise_i(edge_rise),
      .rd_i(rd_i), .cnt_o(cnt_q), .pend_o(rd_pend), .data_o(rd_data_o)
   );
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             rd_i,
   input logic             strobe,
   input logic             rise,
   input logic             pend,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] data_o
);
   logic serve;
   logic was_rst;
   assign serve = strobe & (pend | rd_i);

   always_ff @(posedge clk) was_rst <= rst;

   // R1: reset values seen at the first edge after release
   always @(posedge clk) begin
      if (was_rst === 1'b1 && rst === 1'b0) begin
         a_r1_reset_clear: assert (cnt == '0 && data_o == '0 && !strobe)
            else $error("a_r1_reset_clear");
      end
   end

   a_r2_strobe_gap: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe ##1 !strobe);

   a_r3_edge_on_strobe: assert property (@(posedge clk) disable iff (rst)
      rise |-> strobe);

   a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
      (rise && !serve) |=> cnt == CNT_W'($past(cnt) + 1'b1));

   a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
      (rise && !serve && cnt == {CNT_W{1'b1}}) |=> cnt == '0);

   a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
      (serve && !rise) |=> (cnt == '0 && data_o == $past(cnt)));

   a_r7_edge_kept: assert property (@(posedge clk) disable iff (rst)
      (serve && rise) |=> (cnt == CNT_W'(1) && data_o == $past(cnt)));

   a_r8_data_hold: assert property (@(posedge clk) disable iff (rst)
      !serve |=> $stable(data_o));

   a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!serve && !rise) |=> $stable(cnt));
endmodule

bind pulse_rate_counter prc_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .rd_i(rd_i), .strobe(smp_stb), .rise(edge_rise),
   .pend(rd_pend), .cnt(cnt_q), .data_o(rd_data_o)
);

// File: tb/pulse_rate_counter_bench.sv
module pulse_rate_counter_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       hs  = 1'b0;
   logic       rd  = 1'b0;
   logic [7:0] dout;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;
   bit done     = 0;

   always #2 clk = ~clk;   // 250 MHz

   pulse_rate_counter u_pulse_rate_counter (
      .clk(clk), .rst(rst), .hs_raw_i(hs), .rd_i(rd), .rd_data_o(dout)
   );

   // Behavioural reference model, updated on each rising edge.
   int m_phase, m_s1, m_s2, m_prev, m_cnt, m_data, m_pend;
   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         m_phase = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
         m_cnt = 0; m_data = 0; m_pend = 0;
      end else begin
         int stb, rise, serve;
         stb   = (m_phase == 2);
         m_phase = (m_phase + 1) % 3;
         rise  = stb && m_s2 == 1 && m_prev == 0;
         if (stb) m_prev = m_s2;
         m_s2  = m_s1;
         m_s1  = hs;
         serve = stb && (m_pend || rd);
         m_pend = serve ? 0 : (m_pend || rd);
         if (serve) begin
            m_data = m_cnt;
            m_cnt  = rise ? 1 : 0;
         end else if (rise) begin
            m_cnt = (m_cnt + 1) % 256;
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the model (R2 strobe phase, R6 timing, R8 hold)
   always @(negedge clk) begin
      if (!rst) check("R2 R6 R8 model", dout, m_data);
   end

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         hs = 1'b1; repeat (4) @(negedge clk);
         hs = 1'b0; repeat (4) @(negedge clk);
      end
   endtask

   task automatic do_read(input string tag, input int exp);
      rd = 1'b1; @(negedge clk); rd = 1'b0;
      repeat (4) @(negedge clk);
      check(tag, dout, exp);
   endtask

   initial begin : watchdog
      wait (cycles > 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset data", dout, 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 after release", dout, 0);

      // R3/R5: plain counting
      pulses(5);
      do_read("R3 R5 five pulses", 5);
      do_read("R6 cleared by read", 0);
      pulses(1);
      do_read("R3 single pulse", 1);

      // R8: second request while pending is merged
      pulses(3);
      rd = 1'b1; @(negedge clk); rd = 1'b1; @(negedge clk); rd = 1'b0;
      repeat (4) @(negedge clk);
      check("R8 merged read", dout, 3);
      repeat (10) @(negedge clk);
      check("R8 hold without read", dout, 3);
      do_read("R8 nothing counted", 0);

      // R4: top of range and wrap
      pulses(255);
      do_read("R4 max value", 255);
      pulses(257);
      do_read("R4 wrap to one", 1);

      // R7: edge detected in the cycle the read is served
      hs = 1'b1;
      begin : align
         for (int i = 0; i < 12; i++) begin
            if (m_phase == 2 && m_s2 == 1 && m_prev == 0) begin
               rd = 1'b1;
               disable align;
            end
            @(negedge clk);
         end
      end
      check("R7 aligned read issued", rd, 1);
      @(negedge clk); rd = 1'b0;
      repeat (3) @(negedge clk);
      check("R7 old value returned", dout, 0);
      hs = 1'b0; repeat (6) @(negedge clk);
      do_read("R7 edge kept", 1);

      // R1: reset mid-count
      pulses(4);
      rst = 1'b1; repeat (2) @(negedge clk);
      check("R1 reset mid run", dout, 0);
      rst = 1'b0; @(negedge clk);
      do_read("R1 count cleared", 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule